// File: doc/BRIEF.md
# Double-Buffered Quad DAC Register Bank

This block sits on a simple 16-bit register bus and holds the digital state for four 12-bit DAC channels, numbered 0 to 3. Each channel has a staging register for its code. A shared range word holds a bipolar bit and a gain bit for every channel. Staged values reach the active outputs only when a commit strobe occurs, and a commit strobe is a bus read of a dedicated address. Range bits have one commit address and codes have another. The block drives the four active codes, the per-channel bipolar and gain bits, and a decoded 2-bit range selector for the analog range stage that follows. Conversion is done outside the block.

A mode register holds two bits. The enable bit forces every output code to zero while it is clear. The buffered bit selects how data writes behave. With buffering off, a data write goes straight to the active output. With buffering on, a data write waits in staging until the commit read. Software normally sets the range word and commits it, writes the codes, and then commits all four codes at once so that the channels change in the same cycle.

Top module: `dacbank_quad`

## Requirements
- R1: After a synchronous active-high reset, every output code is 0, all bipolar, gain and range outputs are 0, and the enable and buffered outputs are 0.
- R2: A bus write to byte address 0x14 + 2*i stages bits [11:0] of the write data as the code of channel i, with channel 0 at 0x14 and channel 3 at 0x1A. Bits [15:12] are dropped. In buffered mode the active code does not change on that write.
- R3: A bus read of address 0x02 copies all four staged codes to the active codes together. They are visible on dac_code_o in the cycle after the read.
- R4: With the buffered bit clear, a data write updates that channel's active code in the cycle after the write, with no commit read.
- R5: A bus write to address 0x02 loads the mode register: data bit 1 is enable and data bit 0 is buffered. While enable is 0, all output codes read 0. The stored codes are kept and reappear when enable returns to 1.
- R6: A bus write to address 0x12 stages the range word. For channel i, the bipolar bit is word bit 7-i and the gain bit is word bit 11-i. These bits reach dac_bipolar_o[i] and dac_gain_o[i] only in the cycle after a bus read of 0x12.
- R7: dac_range_o[2i+1:2i] encodes the active range of channel i: 2 is ±10 V (bipolar with gain), 1 is ±5 V (bipolar without gain), 0 is 0 to 10 V (neither bit), and 3 flags gain set without bipolar.
- R8: Accesses to any other address change nothing. This covers odd addresses, addresses past channel 3, reads of data addresses and writes to other registers.
- R9: Reset also clears the staged codes and the staged range word, so commit reads after reset still give zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wdata_i | input | WORD_W | Write data |
| dac_code_o | output | NUM_CH*CODE_W | Active codes, channel i at bits [12i+11:12i] |
| dac_bipolar_o | output | NUM_CH | Active bipolar bit per channel |
| dac_gain_o | output | NUM_CH | Active gain bit per channel |
| dac_range_o | output | 2*NUM_CH | Decoded range per channel |
| dac_enable_o | output | 1 | Mode register enable bit |
| dac_buffered_o | output | 1 | Mode register buffered bit |

## Verification
The bench writes several channels in buffered mode and checks that no output moves until the commit read. A design that committed on the write, or committed only the last channel written, would show early or missing codes. It writes the range word and checks the outputs before and after the range commit, using bit patterns that single out the 7-i and 11-i positions. Mirrored or unshifted bit mapping, or a commit on the write, would give the wrong channel or early bits. The bench also toggles enable over stored codes and probes addresses next to the decoded ones: odd addresses, the slot after channel 3, and reads of data addresses. A gate that cleared the stored codes, or a decoder that is too loose, would then corrupt later commits.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    localparam int WORD_W   = 16;
    localparam int BIP_MSB  = 7;   // channel i bipolar bit = BIP_MSB - i
    localparam int GAIN_MSB = 11;  // channel i gain bit    = GAIN_MSB - i
    localparam int EN_BIT   = 1;
    localparam int BUF_BIT  = 0;

    localparam logic [7:0] OFS_MODE  = 8'h02;  // write: mode, read: commit codes
    localparam logic [7:0] OFS_RANGE = 8'h12;  // write: stage range, read: commit range
    localparam logic [7:0] OFS_DATA0 = 8'h14;  // first channel code slot

    typedef enum logic [1:0] {
        RNG_UNI10    = 2'd0,
        RNG_BIP5     = 2'd1,
        RNG_BIP10    = 2'd2,
        RNG_GAIN_UNI = 2'd3
    } range_e;

    typedef struct packed {
        logic mode_wr;
        logic range_wr;
        logic range_commit;
        logic code_commit;
    } strobe_t;

    typedef struct packed {
        logic enable;
        logic buffered;
    } mode_t;

    function automatic range_e range_of(input logic bip, input logic gain);
        case ({bip, gain})
            2'b11:   return RNG_BIP10;
            2'b10:   return RNG_BIP5;
            2'b00:   return RNG_UNI10;
            default: return RNG_GAIN_UNI;
        endcase
    endfunction

    function automatic logic [7:0] data_ofs(input int idx);
        return OFS_DATA0 + 8'(2 * idx);
    endfunction

endpackage

// File: rtl/dacbank_decode.sv
module dacbank_decode
    import dacbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output strobe_t           strb_o,
    output logic [NUM_CH-1:0] ch_wr_o
);

    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_RANGE = ADDR_W'(OFS_RANGE);

    always_comb begin
        strb_o.mode_wr      = wr_i && (addr_i == A_MODE);
        strb_o.code_commit  = rd_i && (addr_i == A_MODE);
        strb_o.range_wr     = wr_i && (addr_i == A_RANGE);
        strb_o.range_commit = rd_i && (addr_i == A_RANGE);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] A_SLOT = ADDR_W'(data_ofs(i));
        assign ch_wr_o[i] = wr_i && (addr_i == A_SLOT);
    end

    // R8: at most one channel slot decodes per access
    assert_one_slot_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(ch_wr_o));

    // R8: a register write never also stages a channel code
    assert_reg_vs_slot_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (strb_o.mode_wr || strb_o.range_wr) |-> (ch_wr_o == '0));

endmodule

// File: rtl/dacbank_ctrl.sv
module dacbank_ctrl
    import dacbank_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  strobe_t             strb_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output mode_t               mode_o,
    output logic [NUM_CH-1:0]   bipolar_o,
    output logic [NUM_CH-1:0]   gain_o,
    output logic [2*NUM_CH-1:0] range_o
);

    mode_t             mode_q;
    logic [NUM_CH-1:0] wr_bip, wr_gain;
    logic [NUM_CH-1:0] stg_bip_q, stg_gain_q;
    logic [NUM_CH-1:0] act_bip_q, act_gain_q;
    logic              unused_wbits;

    assign unused_wbits = ^wdata_i;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_field
        assign wr_bip[i]        = wdata_i[BIP_MSB - i];
        assign wr_gain[i]       = wdata_i[GAIN_MSB - i];
        assign range_o[2*i +: 2] = range_of(act_bip_q[i], act_gain_q[i]);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q     <= '0;
            stg_bip_q  <= '0;
            stg_gain_q <= '0;
            act_bip_q  <= '0;
            act_gain_q <= '0;
        end else begin
            if (strb_i.mode_wr) begin
                mode_q.enable   <= wdata_i[EN_BIT];
                mode_q.buffered <= wdata_i[BUF_BIT];
            end
            if (strb_i.range_wr) begin
                stg_bip_q  <= wr_bip;
                stg_gain_q <= wr_gain;
            end
            if (strb_i.range_commit) begin
                act_bip_q  <= stg_bip_q;
                act_gain_q <= stg_gain_q;
            end
        end
    end

    assign mode_o    = mode_q;
    assign bipolar_o = act_bip_q;
    assign gain_o    = act_gain_q;

    // R6: committed range follows the staged word
    assert_range_commit_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        strb_i.range_commit |=> (bipolar_o == $past(stg_bip_q)) && (gain_o == $past(stg_gain_q)));

    // R6: without a commit read the active range bits hold
    assert_range_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !strb_i.range_commit |=> $stable(bipolar_o) && $stable(gain_o));

    // R5: mode register takes its bits from the written word
    assert_mode_load_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        strb_i.mode_wr |=> (mode_o.enable == $past(wdata_i[EN_BIT]))
                        && (mode_o.buffered == $past(wdata_i[BUF_BIT])));

endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
    parameter int CODE_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [CODE_W-1:0] wdata_i,
    input  logic              commit_i,
    input  logic              buffered_i,
    output logic [CODE_W-1:0] active_o
);

    logic [CODE_W-1:0] stage_q, active_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q  <= '0;
            active_q <= '0;
        end else begin
            if (wr_i) stage_q <= wdata_i;
            if (wr_i && !buffered_i) active_q <= wdata_i;
            else if (commit_i)       active_q <= stage_q;
        end
    end

    assign active_o = active_q;

    // R2: buffered writes do not reach the output without a commit
    assert_buffered_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (buffered_i && !commit_i) |=> $stable(active_o));

    // R3: a commit moves the staged code to the output
    assert_commit_copy_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (commit_i && !wr_i) |=> (active_o == $past(stage_q)));

    // R4: unbuffered write is visible the next cycle
    assert_direct_write_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && !buffered_i) |=> (active_o == $past(wdata_i)));

endmodule

// File: rtl/dacbank_quad.sv
module dacbank_quad
    import dacbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 4,   // at most 4: range bits sit at 7-i and 11-i
    parameter int CODE_W = 12
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic                     bus_wr_i,
    input  logic                     bus_rd_i,
    input  logic [WORD_W-1:0]        bus_wdata_i,
    output logic [NUM_CH*CODE_W-1:0] dac_code_o,
    output logic [NUM_CH-1:0]        dac_bipolar_o,
    output logic [NUM_CH-1:0]        dac_gain_o,
    output logic [2*NUM_CH-1:0]      dac_range_o,
    output logic                     dac_enable_o,
    output logic                     dac_buffered_o
);

    strobe_t           strb;
    logic [NUM_CH-1:0] ch_wr;
    mode_t             mode;
    logic [CODE_W-1:0] ch_code [NUM_CH];

    dacbank_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_decode (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .addr_i  (bus_addr_i),
        .wr_i    (bus_wr_i),
        .rd_i    (bus_rd_i),
        .strb_o  (strb),
        .ch_wr_o (ch_wr)
    );

    dacbank_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .strb_i    (strb),
        .wdata_i   (bus_wdata_i),
        .mode_o    (mode),
        .bipolar_o (dac_bipolar_o),
        .gain_o    (dac_gain_o),
        .range_o   (dac_range_o)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dacbank_chan #(.CODE_W(CODE_W)) u_chan (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .wr_i       (ch_wr[i]),
            .wdata_i    (bus_wdata_i[CODE_W-1:0]),
            .commit_i   (strb.code_commit),
            .buffered_i (mode.buffered),
            .active_o   (ch_code[i])
        );
        assign dac_code_o[i*CODE_W +: CODE_W] = mode.enable ? ch_code[i] : '0;
    end

    assign dac_enable_o   = mode.enable;
    assign dac_buffered_o = mode.buffered;

    // R5: disabled bank presents only zero codes
    assert_disabled_zero_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !dac_enable_o |-> (dac_code_o == '0));

endmodule

// File: tb/dacbank_quad_tb.sv
`timescale 1ns/1ps
module dacbank_quad_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [47:0] code;
    logic [3:0]  bip, gain;
    logic [7:0]  rng;
    logic        en, bufm;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dacbank_quad u_dut (
        .clk_i          (clk),
        .rst_i          (rst),
        .bus_addr_i     (addr),
        .bus_wr_i       (wr),
        .bus_rd_i       (rd),
        .bus_wdata_i    (wdata),
        .dac_code_o     (code),
        .dac_bipolar_o  (bip),
        .dac_gain_o     (gain),
        .dac_range_o    (rng),
        .dac_enable_o   (en),
        .dac_buffered_o (bufm)
    );

    function automatic logic [11:0] ch(input int i);
        return code[i*12 +: 12];
    endfunction

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0; addr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 codes", code, 48'h0);
        check("R1 bipolar", 48'(bip), 48'h0);
        check("R1 gain", 48'(gain), 48'h0);
        check("R1 range", 48'(rng), 48'h0);
        check("R1 enable/buffered", 48'({en, bufm}), 48'h0);
    endtask

    task automatic t_unbuffered();
        bus_write(8'h02, 16'h0002);
        check("R5 mode enable only", 48'({en, bufm}), 48'h2);
        bus_write(8'h14, 16'h0ABC);
        check("R4 ch0 direct", 48'(ch(0)), 48'hABC);
        bus_write(8'h1A, 16'hF123);
        check("R4 ch3 direct, high bits dropped (R2)", 48'(ch(3)), 48'h123);
        check("R4 ch1/ch2 untouched", 48'({ch(1), ch(2)}), 48'h0);
    endtask

    task automatic t_buffered();
        bus_write(8'h02, 16'h0003);
        bus_write(8'h16, 16'h0456);
        bus_write(8'h18, 16'h0789);
        bus_write(8'h14, 16'h0111);
        check("R2 staged, outputs hold", code, {12'h123, 12'h000, 12'h000, 12'hABC});
        bus_read(8'h02);
        check("R3 all committed", code, {12'h123, 12'h789, 12'h456, 12'h111});
    endtask

    task automatic t_enable();
        bus_write(8'h02, 16'h0001);
        check("R5 disabled codes zero", code, 48'h0);
        check("R5 enable out low", 48'({en, bufm}), 48'h1);
        bus_write(8'h14, 16'h0222);
        bus_write(8'h02, 16'h0003);
        check("R5 codes kept over disable", code, {12'h123, 12'h789, 12'h456, 12'h111});
        bus_read(8'h02);
        check("R3 commit after re-enable", 48'(ch(0)), 48'h222);
    endtask

    task automatic t_range();
        bus_write(8'h12, 16'h0880);
        check("R6 no change before commit", 48'({bip, gain}), 48'h0);
        bus_read(8'h12);
        check("R6 ch0 bits 7/11", 48'({bip, gain}), 48'h11);
        check("R7 ch0 bip10", 48'(rng), 48'h02);
        bus_write(8'h12, 16'h0040);
        bus_read(8'h12);
        check("R6 ch1 bit 6", 48'({bip, gain}), 48'h20);
        check("R7 ch1 bip5", 48'(rng), 48'h04);
        bus_write(8'h12, 16'h0200);
        bus_read(8'h12);
        check("R6 ch2 gain bit 9", 48'({bip, gain}), 48'h04);
        check("R7 ch2 gain-only flag", 48'(rng), 48'h30);
        bus_write(8'h12, 16'h0FF0);
        bus_read(8'h12);
        check("R7 all bip10", 48'(rng), 48'hAA);
        bus_write(8'h12, 16'h0000);
        bus_read(8'h12);
        check("R7 all uni10", 48'(rng), 48'h00);
    endtask

    task automatic t_ignore();
        bus_write(8'h1C, 16'h0333);
        bus_write(8'h15, 16'h0444);
        bus_write(8'h04, 16'h0000);
        bus_write(8'h13, 16'h0FF0);
        bus_read(8'h14);
        bus_read(8'h16);
        check("R8 mode unchanged", 48'({en, bufm}), 48'h3);
        check("R8 codes unchanged", code, {12'h123, 12'h789, 12'h456, 12'h222});
        bus_read(8'h12);
        check("R8 range not staged by odd address", 48'({bip, gain}), 48'h0);
        bus_read(8'h02);
        check("R8 nothing staged by stray writes", code, {12'h123, 12'h789, 12'h456, 12'h222});
    endtask

    task automatic t_rereset();
        bus_write(8'h16, 16'h0555);
        bus_write(8'h12, 16'h0FF0);
        do_reset();
        check("R1 codes after second reset", code, 48'h0);
        bus_write(8'h02, 16'h0003);
        bus_read(8'h02);
        check("R9 staged codes cleared", code, 48'h0);
        bus_read(8'h12);
        check("R9 staged range cleared", 48'({bip, gain}), 48'h0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_unbuffered();
        t_buffered();
        t_enable();
        t_range();
        t_ignore();
        t_rereset();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule